// File: doc/BRIEF.md
# Serial Stereo PCM Receiver

This block takes stereo 16-bit PCM from a three-wire serial link (a bit clock, a word clock and a data line) and turns it into parallel left and right samples. The samples go to a downstream converter or modulator, marked by a single-cycle strobe. All logic runs on the system clock. The three serial lines are passed through synchronizers and oversampled, and the rising edges of the bit clock are found in the system domain. No flop is clocked by the serial bit clock.

Each half of a word-clock period carries one word. Word clock low means the left channel and high means the right channel. The word starts with its most significant bit one bit clock after the word-clock transition. The block accepts a bit clock of 32 or 64 times the sample rate. It works out which of the two is present by counting bit-clock edges per word-clock period, and it raises a framing error for any other count or for a word clock that stops. A stall monitor counts system cycles without a bit-clock edge. When that count reaches a programmable limit, the monitor raises a clock-loss flag. While that flag is up the samples read zero and the receiver resynchronizes from scratch.

The word assembler is a state machine with three states:
- `ST_HUNT`: waits for a word-clock transition.
- `ST_SHIFT`: collects the bits of a word.
- `ST_TAIL`: ignores the slots that remain in a half frame once the word is complete.

Its transitions are:
- HUNT→SHIFT on a word-clock transition.
- SHIFT→TAIL when the 16th bit is taken with no transition.
- SHIFT→SHIFT on a transition. If that transition's slot supplies the 16th bit (32fs case), the word is finished first.
- TAIL→SHIFT on a transition.
- Any state→HUNT on clock loss.

Top module: `serial_pcm_rx`

## Requirements
- R1: After reset, the sample outputs, the strobe, and the lock, ratio, framing-error and clock-loss flags are all 0.
- R2: A word is 16 bits, sent most significant bit first. Its first bit is the data sampled at the second bit-clock rising edge after a word-clock change. The data at the rising edge where the change is first seen is not part of the new word. Word clock 0 selects left and 1 selects right.
- R3: A completed right word that follows a completed left word presents both samples together on `smp_left` and `smp_right`, with `smp_valid` high for exactly one system cycle. Every sent pair appears exactly once, in order.
- R4: With a 64fs bit clock, the data in slots after the 16th bit of a half frame has no effect on the samples.
- R5: With a 32fs bit clock, the least significant bit of a word is taken from the first slot after the next word-clock change.
- R6: A word-clock period (falling edge to falling edge) of exactly 32 bit-clock edges sets `fmt_locked`=1 and `fmt_is64`=0. A period of exactly 64 edges sets `fmt_locked`=1 and `fmt_is64`=1.
- R7: Any other measured period length sets `frame_err`=1 and `fmt_locked`=0. The next good period clears `frame_err`.
- R8: If the word clock stays still for more than 64 bit-clock edges after a falling edge, `frame_err` is set.
- R9: `clk_lost` rises once `stall_limit` consecutive system cycles pass with no bit-clock rising edge. It clears on the next edge.
- R10: While `clk_lost` is 1, the following hold: `smp_left` and `smp_right` read 0, `smp_valid` stays 0, and `fmt_locked` is 0. Reception restarts at the next word-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_wclk | input | 1 | Serial word clock, 0 = left, 1 = right |
| ser_data | input | 1 | Serial data, MSB first |
| stall_limit | input | STALL_W | System cycles without a bit-clock edge before clock loss (must be at least 1) |
| smp_left | output | SMP_W | Left sample of the last pair |
| smp_right | output | SMP_W | Right sample of the last pair |
| smp_valid | output | 1 | One-cycle strobe for a new pair |
| fmt_locked | output | 1 | A valid bit-clock ratio has been measured |
| fmt_is64 | output | 1 | 1 = 64fs, 0 = 32fs |
| frame_err | output | 1 | Period length is neither 32 nor 64 edges, or the word clock has stopped |
| clk_lost | output | 1 | Bit clock has stalled |

## Verification
The hardest case to reach from the ports is the 32fs one. There, a word's last bit arrives in the delay slot of the opposite channel, so a right word completes only when the next left half begins. Ratio changes and stalls must not break that carried bit. The bench drives one serial generator that carries the final bit of each 32fs word into the next half frame. It switches from 64fs to 32fs and back mid-stream, inserts a 24-slot half frame, and stops the bit clock and later the word clock alone. The scoreboard must still see every pair exactly once.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/spr_line_sync.sv
module spr_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out
);
    generate
        for (genvar gi = 0; gi < LINES; gi++) begin : g_line
            logic [STAGES-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], raw_in[gi]};
            end
            assign sync_out[gi] = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spr_stall_mon.sv
module spr_stall_mon #(
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_ev,
    input  logic [STALL_W-1:0] limit,
    output logic               lost
);
    logic [STALL_W-1:0] idle_q;
    logic [STALL_W:0]   idle_nx;

    assign idle_nx = {1'b0, idle_q} + (STALL_W+1)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            lost   <= 1'b0;
        end else if (bit_ev) begin
            idle_q <= '0;
            lost   <= 1'b0;
        end else begin
            if (idle_q != '1) idle_q <= idle_q + STALL_W'(1);
            if (idle_nx >= {1'b0, limit}) lost <= 1'b1;
        end
    end

    AST_EDGE_CLEARS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ev |=> !lost); // R9
    AST_LOSS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> !$past(bit_ev)); // R9
endmodule

// File: rtl/spr_ratio_det.sv
module spr_ratio_det #(
    parameter int SMP_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_ev,
    input  logic ws,
    input  logic lost,
    output logic locked,
    output logic is64,
    output logic frame_err
);
    localparam int LO = 2 * SMP_W;
    localparam int HI = 4 * SMP_W;
    localparam int CW = $clog2(HI + 2) + 1;
    localparam logic [CW-1:0] LO_C = CW'(LO);
    localparam logic [CW-1:0] HI_C = CW'(HI);

    logic [CW-1:0] per_q;
    logic          ws_prev, ws_seen, fall_seen;
    logic          fall_ev;

    assign fall_ev = bit_ev && ws_seen && ws_prev && !ws;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q     <= '0;
            ws_prev   <= 1'b0;
            ws_seen   <= 1'b0;
            fall_seen <= 1'b0;
            locked    <= 1'b0;
            is64      <= 1'b0;
            frame_err <= 1'b0;
        end else if (lost) begin
            per_q     <= '0;
            fall_seen <= 1'b0;
            locked    <= 1'b0;
            frame_err <= 1'b0;
        end else if (bit_ev) begin
            ws_seen <= 1'b1;
            ws_prev <= ws;
            if (fall_ev) begin
                per_q     <= CW'(1);
                fall_seen <= 1'b1;
                if (fall_seen) begin
                    if (per_q == LO_C) begin
                        locked <= 1'b1; is64 <= 1'b0; frame_err <= 1'b0;
                    end else if (per_q == HI_C) begin
                        locked <= 1'b1; is64 <= 1'b1; frame_err <= 1'b0;
                    end else begin
                        locked <= 1'b0; frame_err <= 1'b1;
                    end
                end
            end else if (fall_seen) begin
                if (per_q != '1) per_q <= per_q + CW'(1);
                if (per_q >= HI_C) begin
                    locked    <= 1'b0;
                    frame_err <= 1'b1;
                end
            end
        end
    end

    AST_LOCK_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !frame_err); // R7
    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_ev)); // R6
    AST_LOSS_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !locked); // R10
endmodule

// File: rtl/spr_word_fsm.sv
module spr_word_fsm
    import spr_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_ev,
    input  logic             ws,
    input  logic             sd,
    input  logic             lost,
    output logic [SMP_W-1:0] smp_left,
    output logic [SMP_W-1:0] smp_right,
    output logic             smp_valid
);
    localparam int BW = $clog2(SMP_W);
    localparam logic [BW-1:0] LAST = BW'(SMP_W - 1);

    rx_state_t       state_q, state_nx;
    logic            ws_prev, ws_seen, ws_chg;
    logic [BW-1:0]   nbits;
    logic            chan, have_left;
    logic [SMP_W-1:0] sh_q, left_hold, word_val;
    logic            take_bit, word_done;

    assign ws_chg    = bit_ev && ws_seen && (ws != ws_prev);
    assign take_bit  = bit_ev && (state_q == ST_SHIFT) && (!ws_chg || nbits == LAST);
    assign word_done = take_bit && (nbits == LAST);
    assign word_val  = {sh_q[SMP_W-2:0], sd};

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HUNT:  if (ws_chg) state_nx = ST_SHIFT;
            ST_SHIFT: if (bit_ev && !ws_chg && nbits == LAST) state_nx = ST_TAIL;
            ST_TAIL:  if (ws_chg) state_nx = ST_SHIFT;
            default:  state_nx = ST_HUNT;
        endcase
        if (lost) state_nx = ST_HUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev   <= 1'b0;
            ws_seen   <= 1'b0;
            nbits     <= '0;
            chan      <= 1'b0;
            have_left <= 1'b0;
            sh_q      <= '0;
            left_hold <= '0;
            smp_left  <= '0;
            smp_right <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (bit_ev) begin
                ws_seen <= 1'b1;
                ws_prev <= ws;
            end
            if (lost) begin
                smp_left  <= '0;
                smp_right <= '0;
                have_left <= 1'b0;
                nbits     <= '0;
            end else begin
                if (take_bit) begin
                    sh_q  <= word_val;
                    nbits <= nbits + BW'(1);
                end
                if (ws_chg) begin
                    nbits <= '0;
                    chan  <= ws;
                end
                if (word_done) begin
                    if (!chan) begin
                        left_hold <= word_val;
                        have_left <= 1'b1;
                    end else if (have_left) begin
                        smp_left  <= left_hold;
                        smp_right <= word_val;
                        smp_valid <= 1'b1;
                        have_left <= 1'b0;
                    end
                end
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R3
    AST_VALID_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(bit_ev)); // R3
    AST_LOSS_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> (smp_left == '0 && smp_right == '0 && !smp_valid)); // R10
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx #(
    parameter int SMP_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int STALL_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_bclk,
    input  logic               ser_wclk,
    input  logic               ser_data,
    input  logic [STALL_W-1:0] stall_limit,
    output logic [SMP_W-1:0]   smp_left,
    output logic [SMP_W-1:0]   smp_right,
    output logic               smp_valid,
    output logic               fmt_locked,
    output logic               fmt_is64,
    output logic               frame_err,
    output logic               clk_lost
);
    localparam int LINES = 3;

    logic [LINES-1:0] sync_v;
    logic             bclk_d, bit_ev;

    spr_line_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw_in({ser_data, ser_wclk, ser_bclk}),
        .sync_out(sync_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= sync_v[0];
    end
    assign bit_ev = sync_v[0] && !bclk_d;

    spr_stall_mon #(.STALL_W(STALL_W)) u_stall (
        .clk(clk), .rst_n(rst_n), .bit_ev(bit_ev),
        .limit(stall_limit), .lost(clk_lost)
    );

    spr_ratio_det #(.SMP_W(SMP_W)) u_ratio (
        .clk(clk), .rst_n(rst_n), .bit_ev(bit_ev), .ws(sync_v[1]),
        .lost(clk_lost), .locked(fmt_locked), .is64(fmt_is64),
        .frame_err(frame_err)
    );

    spr_word_fsm #(.SMP_W(SMP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_ev(bit_ev), .ws(sync_v[1]),
        .sd(sync_v[2]), .lost(clk_lost),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid)
    );

    AST_VALID_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !clk_lost); // R10
endmodule

// File: tb/serial_pcm_rx_tb_top.sv
`timescale 1ns/1ps
module serial_pcm_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, wclk = 1'b1, sdat = 1'b0;
    logic [15:0] stall_limit = 16'd40;
    logic [15:0] smp_left, smp_right;
    logic        smp_valid, fmt_locked, fmt_is64, frame_err, clk_lost;

    always #2.5 clk = ~clk;

    serial_pcm_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_bclk(bclk), .ser_wclk(wclk),
        .ser_data(sdat), .stall_limit(stall_limit),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .fmt_locked(fmt_locked), .fmt_is64(fmt_is64),
        .frame_err(frame_err), .clk_lost(clk_lost)
    );

    typedef struct packed { logic [15:0] l; logic [15:0] r; } pair_t;
    pair_t exp_q[$];
    int    n_chk = 0, n_fail = 0;
    logic  carry = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slot(input logic ws, input logic d);
        @(negedge clk); bclk = 1'b0; wclk = ws; sdat = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic half(input logic ws, input logic [15:0] w, input int h);
        for (int k = 0; k < h; k++) begin
            logic d;
            if (k == 0)       d = carry;
            else if (k <= 16) d = w[16-k];
            else              d = ((k % 3) != 0);   // junk, R4
            slot(ws, d);
        end
        carry = (h == 16) ? w[0] : 1'b1;            // R5 carry into next half
    endtask

    task automatic frame(input int h, input logic [15:0] l, input logic [15:0] r);
        exp_q.push_back({l, r});
        half(1'b0, l, h);
        half(1'b1, r, h);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected pair", smp_left, 0);
            end else begin
                pair_t e;
                e = exp_q.pop_front();
                check(smp_left == e.l, "R2 left sample", smp_left, e.l);
                check(smp_right == e.r, "R2 right sample", smp_right, e.r);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({smp_left, smp_right} == 32'd0, "R1 samples", smp_left, 0);
        check({smp_valid, fmt_locked, fmt_is64, frame_err, clk_lost} == 5'd0,
              "R1 flags", {smp_valid, fmt_locked, fmt_is64, frame_err, clk_lost}, 0);

        repeat (3) slot(1'b1, 1'b0);
        // 64fs stream
        frame(32, 16'hA5C3, 16'h1234);
        frame(32, 16'h8001, 16'h7FFE);
        frame(32, 16'hFFFF, 16'h0000);
        check(fmt_locked && fmt_is64, "R6 64fs lock", {fmt_locked, fmt_is64}, 3);
        // 32fs stream
        frame(16, 16'h5A5A, 16'hC0DE);
        frame(16, 16'h0001, 16'h8000);
        frame(16, 16'hBEEF, 16'h4321);
        check(fmt_locked && !fmt_is64, "R6 32fs lock", {fmt_locked, fmt_is64}, 2);
        check(!frame_err, "R7 no error on good periods", frame_err, 0);
        // back to 64fs; first left slot carries the last 32fs LSB (R5)
        frame(32, 16'h2468, 16'h1357);
        // bad period of 48 edges
        frame(24, 16'h0F0F, 16'hF0F0);
        frame(32, 16'h3C3C, 16'hC3C3);
        check(frame_err && !fmt_locked, "R7 bad period flagged", {frame_err, fmt_locked}, 2);
        frame(32, 16'h7777, 16'h9999);
        check(!frame_err && fmt_locked, "R7 error cleared", {frame_err, fmt_locked}, 1);
        // bit clock stall
        @(negedge clk); bclk = 1'b0;
        repeat (20) @(negedge clk);
        check(!clk_lost, "R9 no loss before limit", clk_lost, 0);
        check(smp_left == 16'h7777, "R10 sample held before loss", smp_left, 16'h7777);
        repeat (30) @(negedge clk);
        check(clk_lost, "R9 loss flagged", clk_lost, 1);
        check({smp_left, smp_right} == 32'd0, "R10 samples zero", smp_left, 0);
        check(!fmt_locked, "R10 lock dropped", fmt_locked, 0);
        // resume
        carry = 1'b0;
        slot(1'b1, 1'b0);
        check(!clk_lost, "R9 loss cleared on edge", clk_lost, 1'b0);
        repeat (2) slot(1'b1, 1'b0);
        frame(32, 16'hDEAD, 16'hBEEF);
        frame(32, 16'h0102, 16'h0304);
        frame(32, 16'hFACE, 16'hCAFE);
        check(fmt_locked && fmt_is64, "R10 relock after resume", {fmt_locked, fmt_is64}, 3);
        // word clock stuck while bit clock runs
        repeat (80) slot(1'b1, 1'b0);
        check(frame_err, "R8 stuck word clock", frame_err, 1);
        check(exp_q.size() == 0, "R3 all pairs delivered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule